// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block sits between the byte-wide transmit path of an Ethernet MAC and a PHY's media-independent transmit pins. It runs on the transmit clock that the PHY supplies: 25 MHz at 100 Mb/s, or 2.5 MHz at 10 Mb/s. When a frame is offered, the block first sends a seven-byte 0x55 preamble and the 0xD5 start-of-frame delimiter. It then sends each accepted byte as two nibbles, low nibble first. It raises the transmit-enable line for exactly the span of the frame's symbols.

A mode input selects a reduced serial interface. In that mode each byte leaves one bit per clock on data line 0, least-significant bit first, and data lines 3..1 have their output enables cleared so that a pad ring can release them to high impedance. The mode is sampled only between frames.

Upstream, the block takes a byte stream with valid, ready, last and a per-byte error flag. A flagged byte produces a single-cycle coding error on its first symbol. If the upstream side stops offering bytes before the last one, the block sends one aborting symbol that carries a coding error and then ends the frame.

Top module: `mii_tx_serializer`

## Requirements
- R1: During and straight after reset, txen, txerr, txd and s_ready are all 0.
- R2: In nibble mode a frame begins with fifteen 4'h5 nibbles and then one 4'hD nibble, and txen rises in the same cycle as the first of these nibbles.
- R3: In nibble mode each accepted byte appears as two consecutive symbols, first bits 3:0 and then bits 7:4.
- R4: In serial mode (serial_mode=1 when the frame starts) every symbol drives only txd[0], with txd[3:1]=0 and txd_oe=4'b0001. The preamble is bytes 0x55 (x7) and 0xD5, and every byte is sent bit 0 first over 8 clocks.
- R5: In nibble mode txd_oe=4'b1111, and txd is 4'h0 whenever txen is low.
- R6: txen stays high without a gap from the first preamble symbol to the final symbol of the last byte, and is low in the cycle that follows that final symbol.
- R7: A byte accepted with s_err=1 raises txerr for exactly one cycle, on its first symbol. Other bytes do not raise txerr.
- R8: txerr is never high while txen is low.
- R9: s_ready is high only in the final symbol cycle of the preamble or of a byte that was not marked last. It is never high while txen is low.
- R10: If s_valid is low when the next byte is due in a frame whose last byte has not yet been accepted, one extra symbol is sent with txd=4'h0 and txerr=1, and txen falls in the following cycle.
- R11: serial_mode is sampled only while no frame is in progress. Changing it during a frame leaves that frame's format and txd_oe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_mode | input | 1 | 1 selects one-bit serial signalling, 0 selects nibbles |
| s_valid | input | 1 | Upstream byte is offered |
| s_data | input | 8 | Upstream byte |
| s_last | input | 1 | Offered byte ends the frame |
| s_err | input | 1 | Offered byte is to be sent with a coding error |
| s_ready | output | 1 | Block takes the offered byte at this clock edge |
| txd | output | 4 | Transmit data symbol |
| txd_oe | output | 4 | Per-line output enable for txd |
| txen | output | 1 | Transmit enable |
| txerr | output | 1 | Transmit coding error |

## Verification
The embedded assertions check, on every cycle, the relations that hold regardless of frame content. These are: txerr only under txen, a coding error never lasting two cycles, ready only inside a frame, zero data while idle, the serial-mode enables and the frozen output-enable pattern within a frame. What only the scenarios can show is the symbol content and order: the preamble pattern per mode, the nibble and bit ordering of real bytes, the exact cycle where txen falls, the placement of per-byte errors and the aborting symbol after upstream starvation. The bench's scoreboard compares these symbol by symbol against sequences it derives from the requirements.

// File: rtl/mii_tx_pkg.sv
// Shared types and constants for the MII transmit serializer.
package mii_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_DATA  = 2'd2,
        ST_ABORT = 2'd3
    } tx_state_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

endpackage

// File: rtl/mii_tx_ctrl.sv
// Frame sequencer: walks idle -> preamble -> data bytes -> idle (or abort),
// counts symbols within the current unit and issues the upstream ready.
// Assumes the upstream holds s_valid from the start of a frame until its
// bytes are taken; a missing byte mid-frame turns into an abort symbol.
module mii_tx_ctrl
    import mii_tx_pkg::*;
#(
    parameter int PRE_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int NIB_W     = 4,
    localparam int PRE_SYMS_SER = PRE_BYTES * BYTE_W,
    localparam int PRE_SYMS_NIB = PRE_BYTES * (BYTE_W / NIB_W),
    localparam int CNT_W        = $clog2(PRE_SYMS_SER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_mode,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             load,
    output tx_state_e        state,
    output logic             mode_q,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] PRE_END_SER = CNT_W'(PRE_SYMS_SER - 1);
    localparam logic [CNT_W-1:0] PRE_END_NIB = CNT_W'(PRE_SYMS_NIB - 1);
    localparam logic [CNT_W-1:0] BYTE_END_SER = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] BYTE_END_NIB = CNT_W'(BYTE_W / NIB_W - 1);

    logic             last_q;
    logic [CNT_W-1:0] unit_end;
    logic             at_end;

    // Last symbol index of the unit being sent (preamble or one byte).
    always_comb begin
        if (state == ST_PRE) unit_end = mode_q ? PRE_END_SER : PRE_END_NIB;
        else                 unit_end = mode_q ? BYTE_END_SER : BYTE_END_NIB;
        at_end = (cnt == unit_end);
    end

    // Ready only while the final symbol of a unit that must be followed by a byte is out.
    always_comb begin
        s_ready = at_end && ((state == ST_PRE) || (state == ST_DATA && !last_q));
        load    = s_ready && s_valid;
    end

    // Sequencer state, symbol counter, sampled mode and last-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    mode_q <= serial_mode;
                    cnt    <= '0;
                    if (s_valid) state <= ST_PRE;
                end
                ST_PRE, ST_DATA: begin
                    if (!at_end) begin
                        cnt <= cnt + 1'b1;
                    end else if (state == ST_DATA && last_q) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (s_valid) begin
                        state  <= ST_DATA;
                        cnt    <= '0;
                        last_q <= s_last;
                    end else begin
                        state <= ST_ABORT;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R9: ready is never offered outside a frame.
    a_r9_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ABORT) |-> !s_ready);

endmodule

// File: rtl/mii_tx_symbol.sv
// Symbol generator: holds the byte in flight, shifts it out a nibble or a
// bit per clock, and forms txd/txen/txerr/txd_oe from the sequencer state.
// Assumes load is only raised on the final symbol of a unit.
module mii_tx_symbol
    import mii_tx_pkg::*;
#(
    parameter int PRE_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int NIB_W     = 4,
    localparam int CNT_W    = $clog2(PRE_BYTES * BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_err,
    input  tx_state_e         state,
    input  logic              mode_q,
    input  logic [CNT_W-1:0]  cnt,
    output logic [NIB_W-1:0]  txd,
    output logic [NIB_W-1:0]  txd_oe,
    output logic              txen,
    output logic              txerr
);

    localparam logic [CNT_W-1:0] SFD_IDX = CNT_W'(PRE_BYTES - 1);

    logic [BYTE_W-1:0] sr;
    logic              err_q;
    logic [CNT_W-1:0]  pre_idx;
    logic [BYTE_W-1:0] pre_byte;
    logic              pre_bit;
    logic [NIB_W-1:0]  pre_nib;

    // Byte register: load on handshake, otherwise shift toward bit 0 while sending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            err_q <= 1'b0;
        end else if (load) begin
            sr    <= s_data;
            err_q <= s_err;
        end else if (state == ST_DATA) begin
            sr <= mode_q ? (sr >> 1) : (sr >> NIB_W);
        end
    end

    // Preamble symbol: choose 0x55 or the delimiter, then pick its bit or nibble.
    always_comb begin
        pre_idx  = mode_q ? (cnt >> 3) : (cnt >> 1);
        pre_byte = (pre_idx == SFD_IDX) ? SFD_BYTE : PRE_BYTE;
        pre_bit  = pre_byte[cnt[2:0]];
        pre_nib  = cnt[0] ? pre_byte[7:4] : pre_byte[3:0];
    end

    // Output symbol and line enables per sequencer state.
    always_comb begin
        txd_oe = mode_q ? NIB_W'(1) : '1;
        txd    = '0;
        txen   = 1'b0;
        txerr  = 1'b0;
        case (state)
            ST_PRE: begin
                txen = 1'b1;
                txd  = mode_q ? NIB_W'(pre_bit) : pre_nib;
            end
            ST_DATA: begin
                txen  = 1'b1;
                txd   = mode_q ? NIB_W'(sr[0]) : sr[NIB_W-1:0];
                txerr = err_q && (cnt == '0);
            end
            ST_ABORT: begin
                txen  = 1'b1;
                txerr = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: coding error only inside a frame.
    a_r8_err_under_en: assert property (@(posedge clk) disable iff (!rst_n)
        txerr |-> txen);
    // R7: a coding error lasts a single cycle.
    a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        txerr |=> !txerr);
    // R5: data lines are zero while idle.
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !txen |-> (txd == '0));
    // R4: serial mode drives only line 0.
    a_r4_serial_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && txen) |-> (txd_oe == NIB_W'(1) && txd[NIB_W-1:1] == '0));

endmodule

// File: rtl/mii_tx_serializer.sv
// MII transmit serializer top: byte stream in, preamble + nibbles (or serial
// bits on line 0) out, timed by the PHY transmit clock. Assumes the byte
// stream is already in this clock domain and carries its own CRC.
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int PRE_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int NIB_W     = 4,
    localparam int CNT_W    = $clog2(PRE_BYTES * BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic [NIB_W-1:0]  txd,
    output logic [NIB_W-1:0]  txd_oe,
    output logic              txen,
    output logic              txerr
);

    tx_state_e        state;
    logic             mode_q;
    logic [CNT_W-1:0] cnt;
    logic             load;

    mii_tx_ctrl #(.PRE_BYTES(PRE_BYTES), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
        .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .load(load), .state(state), .mode_q(mode_q), .cnt(cnt)
    );

    mii_tx_symbol #(.PRE_BYTES(PRE_BYTES), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) sym_i (
        .clk(clk), .rst_n(rst_n), .load(load), .s_data(s_data), .s_err(s_err),
        .state(state), .mode_q(mode_q), .cnt(cnt),
        .txd(txd), .txd_oe(txd_oe), .txen(txen), .txerr(txerr)
    );

    // R9: ready implies the frame is on the wire.
    a_r9_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> txen);
    // R11: line enables do not change within a frame.
    a_r11_oe_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && $past(txen)) |-> $stable(txd_oe));

endmodule

// File: tb/mii_tx_serializer_tb.sv
// Scoreboard bench: the driver pushes each frame's expected symbols into a
// queue, the monitor pops and compares while txen is high.
module mii_tx_serializer_tb_top;

    typedef struct packed {
        logic [3:0] oe;
        logic [3:0] txd;
        logic       err;
        logic       fin;
    } sym_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_mode = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_err = 1'b0;
    logic       s_ready;
    logic [3:0] txd, txd_oe;
    logic       txen, txerr;

    int   checks = 0;
    int   fails  = 0;
    int   cycles = 0;
    logic in_frame = 1'b0;
    logic done = 1'b0;
    sym_t exp_q[$];
    logic [7:0] fb[8];

    always #2 clk = ~clk;

    mii_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
        .s_ready(s_ready), .txd(txd), .txd_oe(txd_oe), .txen(txen), .txerr(txerr)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic push_byte(input logic ser, input logic [7:0] b, input logic e, input logic fin);
        if (ser) begin
            for (int k = 0; k < 8; k++)
                exp_q.push_back('{4'b0001, {3'b000, b[k]}, e && k == 0, fin && k == 7});
        end else begin
            exp_q.push_back('{4'b1111, b[3:0], e, 1'b0});
            exp_q.push_back('{4'b1111, b[7:4], 1'b0, fin});
        end
    endtask

    // Drive one frame of n bytes from fb; err_idx flags one byte; abort omits last.
    task automatic send_frame(input int n, input logic ser, input int err_idx,
                              input logic abort, input logic flip);
        for (int p = 0; p < 8; p++) push_byte(ser, (p == 7) ? 8'hD5 : 8'h55, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) push_byte(ser, fb[i], i == err_idx, !abort && i == n - 1);
        if (abort) exp_q.push_back('{ser ? 4'b0001 : 4'b1111, 4'h0, 1'b1, 1'b1});
        @(negedge clk);
        serial_mode = ser;
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1;
            s_data  = fb[i];
            s_last  = !abort && i == n - 1;
            s_err   = (i == err_idx);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            if (flip && i == 0) serial_mode = ~ser;  // R11 mid-frame mode change
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_err   = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare symbols, gap/extra detection, idle and ready rules.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            if (s_ready) check(txen, "R9 ready outside frame", s_ready, 0);
            if (!txen) begin
                check(!txerr, "R8 txerr without txen", txerr, 0);
                check(txd == 4'h0, "R5 idle txd", txd, 0);
                check(!in_frame, "R6 txen gap", txen, 1);
                in_frame = 1'b0;
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R6 extra symbol", txd, 0);
            end else begin
                sym_t e;
                e = exp_q.pop_front();
                check({txd_oe, txd, txerr} == {e.oe, e.txd, e.err},
                      "R2/R3/R4/R5/R7/R10/R11 symbol", {txd_oe, txd, txerr}, {e.oe, e.txd, e.err});
                in_frame = !e.fin;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txen == 1'b0 && txerr == 1'b0 && txd == 4'h0 && s_ready == 1'b0,
              "R1 reset outputs", {txen, txerr, txd, s_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(txen == 1'b0 && s_ready == 1'b0, "R1 after reset", {txen, s_ready}, 0);
        // R2 R3 R6: plain nibble frame
        fb[0] = 8'h12; fb[1] = 8'hA7; fb[2] = 8'h3C;
        send_frame(3, 1'b0, -1, 1'b0, 1'b0);
        // R7: nibble frame with error on middle byte
        fb[0] = 8'hF0; fb[1] = 8'h5E; fb[2] = 8'h81; fb[3] = 8'h00;
        send_frame(4, 1'b0, 1, 1'b0, 1'b0);
        // R4 R11: serial frame, mode flipped mid-frame
        fb[0] = 8'hB4; fb[1] = 8'h0F; fb[2] = 8'h69;
        send_frame(3, 1'b1, -1, 1'b0, 1'b1);
        // R5: back to nibble mode, single byte frame
        fb[0] = 8'hC3;
        send_frame(1, 1'b0, -1, 1'b0, 1'b0);
        // R10: nibble abort after two bytes
        fb[0] = 8'h9A; fb[1] = 8'h77;
        send_frame(2, 1'b0, -1, 1'b1, 1'b0);
        // R10 R7: serial abort with first byte flagged
        fb[0] = 8'h2D; fb[1] = 8'hE1;
        send_frame(2, 1'b1, 0, 1'b1, 1'b0);
        check(exp_q.size() == 0, "R6 all symbols sent", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule